// File: doc/BRIEF.md
# Clocked host controller for an asynchronous 64K x 16 static RAM

The controller sits between a synchronous host and an asynchronous static RAM. The host presents a single request with a read/write flag, a word address, write data and one active-high enable per byte lane. The controller then drives the memory's active-low chip select, output enable, write strobe and per-lane enables, together with the address and a split data bus (outgoing word, incoming word, drive enable). Every memory-facing output comes from a flop, so no decode glitch can reach the RAM.

The analog minimums are written in nanoseconds: 55 ns access cycle, 40 ns write pulse, 25 ns data setup, 20 ns bus release after output enable rises, and 100 us after power-up. The controller converts each of them into a whole number of clocks at elaboration: the ceiling of the time divided by the clock period, with at least one cycle. `host_ready` is high only while the controller is idle and the power-up wait has finished. `host_done` pulses for one clock when an access finishes. Read data stays on `host_rdata` until the next read completes.

Top module: `sram_link_ctrl`

## Requirements
- R1: During reset and whenever the controller is idle, `mem_ce_n`, `mem_oe_n`, `mem_we_n` and both bits of `mem_be_n` are high and `mem_dq_oe` is low. While reset is asserted, `host_ready`, `host_done` and `host_rdata` are zero.
- R2: After reset is released, `host_ready` stays low for PU = ceil(T_POWERUP_NS / CLK_NS) clock edges and rises after edge PU. A request held during that time starts no memory access.
- R3: A write stores `host_wdata[7:0]` only when `host_be[0]` is 1 and `host_wdata[15:8]` only when `host_be[1]` is 1. `mem_be_n` equals the bitwise inverse of `host_be`, and `mem_addr` equals `host_addr`. With both enable bits 0 the memory is unchanged.
- R4: In the first cycle of a write, address, data, `mem_dq_oe`, chip select and lane enables are driven while `mem_we_n` is still high. `mem_we_n` is then low for WP = max(ceil(40/CLK_NS), ceil(25/CLK_NS)) cycles, followed by TL = max(1, RC - 1 - WP) cycles with the chip still selected. Here RC = ceil(55/CLK_NS). `host_done` is high in cycle 1 + WP + TL + 1, counting the cycle after acceptance as cycle 1.
- R5: A read holds `mem_ce_n` and `mem_oe_n` low and `mem_we_n` high for RC cycles. The data bus is captured at the end of the last of those cycles, and `host_done` is high in cycle RC + 1. Lanes whose `host_be` bit is 0 read as zero.
- R6: After a read ends, the controller stays busy for HZ = ceil(20/CLK_NS) cycles with `mem_dq_oe` low before `host_ready` returns. `mem_dq_oe` never rises less than 20 ns after `mem_oe_n` rises.
- R7: `host_done` is high for exactly one clock per access.
- R8: A request made while `host_ready` is low starts no memory access. Each accepted request gives exactly one falling edge of `mem_ce_n`.
- R9: `host_rdata` keeps the last read result through later writes until the next read completes.
- R10: `mem_oe_n` and `mem_we_n` are never low together. `mem_we_n` is low only while `mem_ce_n` is low and `mem_dq_oe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, period CLK_NS |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Access request, taken when `host_ready` is high |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | DATA_W | Write data |
| host_be | input | DATA_W/8 | Byte-lane enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| host_ready | output | 1 | Idle and able to accept a request |
| host_done | output | 1 | One-clock pulse when an access completes |
| host_rdata | output | DATA_W | Data from the last completed read |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_be_n | output | DATA_W/8 | Per-lane enables, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_in | input | DATA_W | Data returned by the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |

## Verification
If the phase counter reloads with a wrong count, the access latency seen on `host_done` is off, and this shows on the first access. A read capture that is too early returns garbage, because the memory model only presents stored data 55 ns after select. If the state leaves a strobe low, two strobes overlap or the turnaround is skipped, the timing monitors in the model catch it at the next write end or the next rise of bus drive. If the lane decode or the read masking is wrong, the shadow comparison fails on the first access that uses a partial lane pattern.

// File: rtl/sram_link_pkg.sv
package sram_link_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_READ,
    PH_TURN,
    PH_WSET,
    PH_WPULSE,
    PH_WTAIL
  } phase_e;

  // clocks needed to cover a time span: ceiling, never below one
  function automatic int ns_to_cyc(input int span_ns, input int period_ns);
    int c;
    c = (span_ns + period_ns - 1) / period_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_link_powerup.sv
module sram_link_powerup #(
  parameter int PU_CYC = 10000
) (
  input  logic clk,
  input  logic rst,
  output logic pu_ok
);
  localparam int PU_W = $clog2(PU_CYC + 1);

  logic [PU_W-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_cnt <= '0;
      pu_ok    <= 1'b0;
    end else if (!pu_ok) begin
      if (wait_cnt == PU_W'(PU_CYC - 1)) pu_ok <= 1'b1;
      else wait_cnt <= wait_cnt + 1'b1;
    end
  end

  // R2
  pu_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    pu_ok |=> pu_ok);

endmodule

// File: rtl/sram_link_phase.sv
module sram_link_phase #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)                remain <= '0;
    else if (load)          remain <= load_val;
    else if (remain != '0)  remain <= remain - 1'b1;
  end

  assign expire = (remain == '0);

endmodule

// File: rtl/sram_link_ctrl.sv
module sram_link_ctrl
  import sram_link_pkg::*;
#(
  parameter int CLK_NS        = 10,
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 16,
  parameter int T_CYCLE_NS    = 55,
  parameter int T_WPULSE_NS   = 40,
  parameter int T_WSETUP_NS   = 25,
  parameter int T_RELEASE_NS  = 20,
  parameter int T_POWERUP_NS  = 100000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                host_req,
  input  logic                host_wr,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic [DATA_W-1:0]   host_wdata,
  input  logic [DATA_W/8-1:0] host_be,
  output logic                host_ready,
  output logic                host_done,
  output logic [DATA_W-1:0]   host_rdata,
  output logic                mem_ce_n,
  output logic                mem_oe_n,
  output logic                mem_we_n,
  output logic [DATA_W/8-1:0] mem_be_n,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_dq_out,
  input  logic [DATA_W-1:0]   mem_dq_in,
  output logic                mem_dq_oe
);
  localparam int BE_W   = DATA_W / 8;
  localparam int N_RC   = ns_to_cyc(T_CYCLE_NS, CLK_NS);
  localparam int N_PWE  = imax(ns_to_cyc(T_WPULSE_NS, CLK_NS), ns_to_cyc(T_WSETUP_NS, CLK_NS));
  localparam int N_TAIL = imax(1, N_RC - 1 - N_PWE);
  localparam int N_HZ   = ns_to_cyc(T_RELEASE_NS, CLK_NS);
  localparam int N_PU   = ns_to_cyc(T_POWERUP_NS, CLK_NS);
  localparam int N_SET  = 1;
  localparam int N_MAX  = imax(imax(N_RC, N_PWE), imax(N_TAIL, N_HZ));
  localparam int CNT_W  = $clog2(N_MAX + 1);

  function automatic logic [DATA_W-1:0] lane_mask(input logic [BE_W-1:0] be);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < BE_W; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction

  phase_e           phase;
  logic             pu_ok;
  logic             ph_expire;
  logic             ph_load;
  logic [CNT_W-1:0] ph_val;
  logic [BE_W-1:0]  be_q;
  logic             accept;

  sram_link_powerup #(.PU_CYC(N_PU)) u_pu (
    .clk   (clk),
    .rst   (rst),
    .pu_ok (pu_ok)
  );

  sram_link_phase #(.CNT_W(CNT_W)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .load     (ph_load),
    .load_val (ph_val),
    .expire   (ph_expire)
  );

  assign host_ready = pu_ok && (phase == PH_IDLE);
  assign accept     = host_req && host_ready;

  // length of the phase being entered
  always_comb begin
    ph_load = 1'b0;
    ph_val  = '0;
    unique case (phase)
      PH_IDLE:   if (accept) begin
                   ph_load = 1'b1;
                   ph_val  = host_wr ? CNT_W'(N_SET - 1) : CNT_W'(N_RC - 1);
                 end
      PH_READ:   if (ph_expire) begin ph_load = 1'b1; ph_val = CNT_W'(N_HZ - 1);   end
      PH_WSET:   if (ph_expire) begin ph_load = 1'b1; ph_val = CNT_W'(N_PWE - 1);  end
      PH_WPULSE: if (ph_expire) begin ph_load = 1'b1; ph_val = CNT_W'(N_TAIL - 1); end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      mem_ce_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_be_n   <= '1;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
      be_q       <= '0;
      host_done  <= 1'b0;
      host_rdata <= '0;
    end else begin
      host_done <= 1'b0;
      unique case (phase)
        PH_IDLE: if (accept) begin
          mem_addr <= host_addr;
          mem_be_n <= ~host_be;
          be_q     <= host_be;
          mem_ce_n <= 1'b0;
          if (host_wr) begin
            mem_dq_out <= host_wdata;
            mem_dq_oe  <= 1'b1;
            phase      <= PH_WSET;
          end else begin
            mem_oe_n <= 1'b0;
            phase    <= PH_READ;
          end
        end
        PH_READ: if (ph_expire) begin
          host_rdata <= mem_dq_in & lane_mask(be_q);
          mem_ce_n   <= 1'b1;
          mem_oe_n   <= 1'b1;
          mem_be_n   <= '1;
          host_done  <= 1'b1;
          phase      <= PH_TURN;
        end
        PH_TURN: if (ph_expire) phase <= PH_IDLE;
        PH_WSET: if (ph_expire) begin
          mem_we_n <= 1'b0;
          phase    <= PH_WPULSE;
        end
        PH_WPULSE: if (ph_expire) begin
          mem_we_n <= 1'b1;
          phase    <= PH_WTAIL;
        end
        PH_WTAIL: if (ph_expire) begin
          mem_ce_n  <= 1'b1;
          mem_be_n  <= '1;
          mem_dq_oe <= 1'b0;
          host_done <= 1'b1;
          phase     <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  logic [CNT_W:0] we_low_cnt;
  always_ff @(posedge clk) begin
    if (rst || mem_we_n) we_low_cnt <= '0;
    else                 we_low_cnt <= we_low_cnt + 1'b1;
  end

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));

  // R10
  we_needs_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce_n && mem_dq_oe));

  // R4
  we_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dq_out) && !mem_ce_n));

  // R4
  we_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_low_cnt >= (CNT_W+1)'(N_PWE)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    host_done |=> !host_done);

  // R2
  pu_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !pu_ok |-> (mem_ce_n && !host_ready));

  // R6
  drive_after_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> ($past(mem_oe_n) && mem_oe_n));

endmodule

// File: tb/sram_link_ctrl_tb.sv
`timescale 1ns/1ps
module sram_link_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int BW = 2;

  function automatic int b_cyc(input int ns);
    int c;
    c = ns / CLK_PERIOD;
    if (c * CLK_PERIOD < ns) c++;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int E_RC   = b_cyc(55);
  localparam int E_PWE  = (b_cyc(40) > b_cyc(25)) ? b_cyc(40) : b_cyc(25);
  localparam int E_TAIL = (E_RC - 1 - E_PWE > 1) ? (E_RC - 1 - E_PWE) : 1;
  localparam int E_HZ   = b_cyc(20);
  localparam int E_PU   = b_cyc(100000);

  function automatic logic [15:0] b_mask(input logic [1:0] be);
    return {(be[1] ? 8'hFF : 8'h00), (be[0] ? 8'hFF : 8'h00)};
  endfunction

  function automatic logic [15:0] b_seed_word(input int i);
    return 16'(i * 16'h0101) ^ 16'h5A3C;
  endfunction

  logic          clk, rst;
  logic          host_req, host_wr;
  logic [AW-1:0] host_addr;
  logic [DW-1:0] host_wdata;
  logic [BW-1:0] host_be;
  logic          host_ready, host_done;
  logic [DW-1:0] host_rdata;
  logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [BW-1:0] mem_be_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_out, mem_dq_in;

  sram_link_ctrl #(.CLK_NS(CLK_PERIOD)) u_dut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_be(host_be),
    .host_ready(host_ready), .host_done(host_done), .host_rdata(host_rdata),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_be_n(mem_be_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 0;
  bit  started = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- memory model ----------------
  logic [15:0] mdl    [0:255];
  logic [15:0] shadow [0:255];
  logic        rd_valid = 1'b0;
  time         t_we_fall = 0, t_dat = 0, t_addr = 0, t_oe_rise = 0, t_ce_fall = 0;
  int          acc_cnt = 0;

  initial for (int i = 0; i < 256; i++) begin
    mdl[i]    = b_seed_word(i);
    shadow[i] = b_seed_word(i);
  end

  always @(negedge mem_ce_n) begin
    acc_cnt++;
    t_ce_fall = $time;
    rd_valid  = 1'b0;
    #55;
    rd_valid  = !mem_ce_n;
  end
  always @(posedge mem_ce_n) rd_valid = 1'b0;
  always @(negedge mem_we_n) t_we_fall = $time;
  always @(mem_dq_out)       t_dat = $time;
  always @(mem_addr)         t_addr = $time;
  always @(posedge mem_oe_n) t_oe_rise = $time;

  logic [15:0] rd_word;
  assign rd_word = mdl[mem_addr[7:0]];
  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n && rd_valid)
                     ? {(mem_be_n[1] ? 8'hEE : rd_word[15:8]), (mem_be_n[0] ? 8'hEE : rd_word[7:0])}
                     : 16'hBAD0;

  always @(posedge mem_we_n) if (started) begin
    chk(!mem_ce_n, "R4", "chip selected at write end", {31'd0, mem_ce_n}, 32'd0);
    chk(mem_dq_oe, "R10", "data driven at write end", {31'd0, mem_dq_oe}, 32'd1);
    chk(($time - t_we_fall) >= 40, "R4", "write pulse ns", 32'($time - t_we_fall), 32'd40);
    chk(($time - t_dat) >= 25, "R4", "data setup ns", 32'($time - t_dat), 32'd25);
    chk(($time - t_addr) >= 40, "R4", "address setup ns", 32'($time - t_addr), 32'd40);
    chk(($time - t_ce_fall) >= 40, "R4", "select to write end ns", 32'($time - t_ce_fall), 32'd40);
    if (!mem_be_n[0]) mdl[mem_addr[7:0]][7:0]  = mem_dq_out[7:0];
    if (!mem_be_n[1]) mdl[mem_addr[7:0]][15:8] = mem_dq_out[15:8];
  end

  always @(posedge mem_dq_oe) if (started)
    chk(($time - t_oe_rise) >= 20, "R6", "release before drive ns", 32'($time - t_oe_rise), 32'd20);

  // ---------------- access task ----------------
  int          exp_acc = 0;
  logic [15:0] last_rd = 16'h0;

  task automatic do_access(input bit wr, input logic [15:0] a, input logic [15:0] d,
                           input logic [1:0] be, input bit poke);
    int n;
    int m;
    logic [15:0] e;
    while (!host_ready) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && (mem_be_n == 2'b11) && !mem_dq_oe,
        "R1", "idle strobes", {27'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_be_n}, 32'h1F);
    host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d; host_be = be;
    @(negedge clk);
    host_req = 1'b0;
    n = 1;
    exp_acc++;
    chk(mem_addr == a, wr ? "R3" : "R5", "address pins", {16'd0, mem_addr}, {16'd0, a});
    chk(mem_be_n == ~be, "R3", "lane enables", {30'd0, mem_be_n}, {30'd0, ~be});
    chk(!mem_ce_n && mem_we_n && (mem_oe_n == wr) && (mem_dq_oe == wr),
        wr ? "R4" : "R5", "first cycle strobes",
        {28'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, {28'd0, 1'b0, wr, 1'b1, wr});
    if (wr) chk(mem_dq_out == d, "R4", "write data pins", {16'd0, mem_dq_out}, {16'd0, d});
    @(negedge clk); n++;
    if (wr) chk(!mem_we_n, "R4", "strobe after setup", {31'd0, mem_we_n}, 32'd0);
    if (poke) begin
      host_req = 1'b1; host_addr = a ^ 16'h00FF; host_wr = 1'b1; host_be = 2'b11;
    end
    while (!host_done && n < 60) begin
      @(negedge clk); n++;
      if (poke && n == 3) host_req = 1'b0;
    end
    host_req = 1'b0;
    if (wr) begin
      chk(n == 1 + E_PWE + E_TAIL + 1, "R4", "write latency", n, 1 + E_PWE + E_TAIL + 1);
      if (be[0]) shadow[a[7:0]][7:0]  = d[7:0];
      if (be[1]) shadow[a[7:0]][15:8] = d[15:8];
      chk(mdl[a[7:0]] == shadow[a[7:0]], "R3", "stored word", {16'd0, mdl[a[7:0]]}, {16'd0, shadow[a[7:0]]});
      chk(host_rdata == last_rd, "R9", "read data held", {16'd0, host_rdata}, {16'd0, last_rd});
      chk(host_ready, "R4", "ready with done after write", {31'd0, host_ready}, 32'd1);
    end else begin
      chk(n == E_RC + 1, "R5", "read latency", n, E_RC + 1);
      e = shadow[a[7:0]] & b_mask(be);
      chk(host_rdata == e, "R5", "read data", {16'd0, host_rdata}, {16'd0, e});
      last_rd = e;
      chk(!host_ready && !mem_dq_oe, "R6", "busy after read", {30'd0, host_ready, mem_dq_oe}, 32'd0);
      m = 0;
      while (!host_ready && m < 60) begin @(negedge clk); m++; end
      chk(m == E_HZ, "R6", "turnaround cycles", m, E_HZ);
    end
    @(negedge clk);
    chk(!host_done, "R7", "done one clock", {31'd0, host_done}, 32'd0);
    chk(acc_cnt == exp_acc, "R8", "access count", acc_cnt, exp_acc);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'h5EED_1234));
    rst = 1'b1; host_req = 1'b0; host_wr = 1'b0; host_addr = '0; host_wdata = '0; host_be = '0;
    repeat (4) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && (mem_be_n == 2'b11) && !mem_dq_oe,
        "R1", "reset strobes", {27'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_be_n}, 32'h1F);
    chk(!host_ready && !host_done && host_rdata == 16'h0, "R1", "reset host side",
        {14'd0, host_ready, host_done, host_rdata}, 32'd0);
    started = 1;
    rst = 1'b0;
    host_req = 1'b1; host_wr = 1'b1; host_addr = 16'h0042; host_wdata = 16'hFFFF; host_be = 2'b11;
    for (int k = 1; k < E_PU; k++) @(negedge clk);
    chk(!host_ready, "R2", "ready during wait", {31'd0, host_ready}, 32'd0);
    chk(acc_cnt == 0, "R2", "no access during wait", acc_cnt, 0);
    host_req = 1'b0;
    @(negedge clk);
    chk(host_ready, "R2", "ready after wait", {31'd0, host_ready}, 32'd1);

    // directed corner cases
    do_access(1, 16'hA512, 16'h1234, 2'b11, 0);
    do_access(0, 16'hA512, 16'h0000, 2'b11, 0);
    do_access(1, 16'hA512, 16'hCDEF, 2'b01, 0);
    do_access(0, 16'hA512, 16'h0000, 2'b11, 0);
    do_access(1, 16'h0512, 16'h77AA, 2'b10, 1);
    do_access(0, 16'hA512, 16'h0000, 2'b01, 0);
    do_access(0, 16'hA512, 16'h0000, 2'b10, 0);
    do_access(1, 16'hFF00, 16'h9999, 2'b00, 0);
    do_access(0, 16'hFF00, 16'h0000, 2'b11, 0);
    do_access(0, 16'h0000, 16'h0000, 2'b00, 0);
    do_access(1, 16'h0003, 16'h5555, 2'b11, 1);
    do_access(1, 16'h0004, 16'h6666, 2'b11, 0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      bit          w;
      logic [15:0] a;
      logic [15:0] d;
      logic [1:0]  b;
      w = 1'($urandom);
      a = 16'($urandom);
      d = 16'($urandom);
      b = 2'($urandom);
      if ((i % 7) == 0) b = 2'b11;
      do_access(w, a, d, b, (i % 11) == 5);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule